// File: doc/BRIEF.md
# ADC Window Compare Monitor

This block sits beside an ADC result stream and wakes the system only when a conversion result satisfies a programmed threshold condition. Once armed by a start pulse it holds its conversion request high, so that conversions keep arriving back to back. It judges each one against a low threshold, a high threshold or both. On the first result that qualifies it drops the request, stores that result, records which side fired and raises a sticky interrupt. To software the whole sequence looks like one single-shot measurement.

Thresholds are always written at 16-bit scale. When the converter runs at 12-bit resolution the block scales both thresholds down by four bit positions and uses only the low twelve bits of each result. The comparison is built from two raw primitives, "greater or equal" and "less than". The block offsets the limits by one where needed so that each single-sided limit includes its own boundary. Writing the low threshold above the high threshold turns the out-of-range detector into an in-range detector with both ends included.

The state machine has three states. IDLE is the state after reset. ARMED holds the conversion request high. DONE is entered after a match. The transitions are: IDLE to ARMED on start; ARMED to DONE on a valid, matching result; DONE to ARMED on start. Every other condition keeps the current state. A start pulse while ARMED has no effect.

Top module: `adc_window_monitor`

## Requirements
- R1: After reset, conv_req, irq, result_data, result_low and result_high are all 0, and the state is IDLE.
- R2: When only low_en is set, a result matches when it is less than or equal to the low threshold.
- R3: When only high_en is set, a result matches when it is greater than or equal to the high threshold.
- R4: When both enables are set and low_thr <= high_thr, a result matches when it is strictly below low_thr, which sets result_low, or strictly above high_thr, which sets result_high.
- R5: When both enables are set and low_thr > high_thr, a result matches when high_thr <= result <= low_thr, and both result_low and result_high are set.
- R6: When neither enable is set, no result matches and conv_req stays high.
- R7: A start pulse in IDLE or DONE raises conv_req from the next cycle. conv_req stays high through non-matching results and is low from the cycle after the edge that takes in the matching result. A start pulse while ARMED has no effect.
- R8: On a match, from the next cycle irq is 1, result_data holds the compared result and the two side flags show which condition fired.
- R9: irq is sticky and is cleared only by irq_clear. If irq_clear and a match fall on the same edge, the match wins and irq stays 1.
- R10: With wide_mode = 0 (12-bit), both thresholds are shifted right by 4 before the compare, smp_data[15:12] is ignored, and result_data holds the 12-bit value with its upper four bits at zero. wide_mode = 1 uses all 16 bits unchanged.
- R11: A result presented while not ARMED is ignored: result_data, the flags and irq do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that arms monitoring |
| irq_clear | input | 1 | Clears the sticky interrupt |
| low_en | input | 1 | Enables the low-limit condition |
| high_en | input | 1 | Enables the high-limit condition |
| wide_mode | input | 1 | 1 = 16-bit results, 0 = 12-bit results |
| low_thr | input | 16 | Low threshold at 16-bit scale |
| high_thr | input | 16 | High threshold at 16-bit scale |
| smp_valid | input | 1 | Conversion result valid |
| smp_data | input | 16 | Conversion result |
| conv_req | output | 1 | Continuous conversion request while armed |
| irq | output | 1 | Sticky wake-up interrupt |
| result_data | output | 16 | Latched matching result, scaled to the active resolution |
| result_low | output | 1 | Low-side condition fired |
| result_high | output | 1 | High-side condition fired |

## Verification
Two functions can act on the same clock edge: a software interrupt clear, and a fresh match that sets the interrupt. The bench provokes this by leaving irq set from an earlier match, re-arming, and then driving a matching result together with irq_clear in the same cycle. irq must still read 1 after that edge, because setting takes priority over clearing. A cycle-accurate reference model decides separately whether each result is a match, and the expected captures are checked against the falling edges of conv_req.

// File: rtl/adc_wm_pkg.sv
package adc_wm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DONE  = 2'd2
    } wm_state_e;

    typedef struct packed {
        logic hit;
        logic low_side;
        logic high_side;
    } wm_verdict_t;

endpackage

// File: rtl/adc_wm_scale.sv
module adc_wm_scale #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 12
) (
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] low_thr,
    input  logic [DATA_W-1:0] high_thr,
    input  logic [DATA_W-1:0] smp_data,
    output logic [DATA_W-1:0] lo_s,
    output logic [DATA_W-1:0] hi_s,
    output logic [DATA_W-1:0] smp_s
);
    localparam int SHIFT = DATA_W - NARROW_W;

    generate
        if (SHIFT > 0) begin : g_narrow
            logic [DATA_W-1:0] lo_n, hi_n, smp_n;
            assign lo_n  = {{SHIFT{1'b0}}, low_thr[DATA_W-1:SHIFT]};
            assign hi_n  = {{SHIFT{1'b0}}, high_thr[DATA_W-1:SHIFT]};
            assign smp_n = {{SHIFT{1'b0}}, smp_data[NARROW_W-1:0]};
            assign lo_s  = wide_mode ? low_thr  : lo_n;
            assign hi_s  = wide_mode ? high_thr : hi_n;
            assign smp_s = wide_mode ? smp_data : smp_n;
        end else begin : g_same
            logic unused_mode;
            assign unused_mode = wide_mode;
            assign lo_s  = low_thr;
            assign hi_s  = high_thr;
            assign smp_s = smp_data;
        end
    endgenerate

endmodule

// File: rtl/adc_wm_compare.sv
module adc_wm_compare
    import adc_wm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         low_en,
    input  logic         high_en,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] smp,
    output wm_verdict_t  verdict
);
    localparam int XW = W + 1;

    // The two raw compare primitives
    function automatic logic prim_ge(input logic [XW-1:0] a, input logic [XW-1:0] b);
        return a >= b;
    endfunction

    function automatic logic prim_lt(input logic [XW-1:0] a, input logic [XW-1:0] b);
        return a < b;
    endfunction

    logic [XW-1:0] s_x, lo_x, hi_x, lo_p1, hi_p1;
    logic          inverted;
    logic          in_range;

    assign s_x   = {1'b0, smp};
    assign lo_x  = {1'b0, lo};
    assign hi_x  = {1'b0, hi};
    assign lo_p1 = lo_x + XW'(1);   // moves "less than" onto an inclusive bound
    assign hi_p1 = hi_x + XW'(1);   // moves "at or above" onto a strict bound
    assign inverted = prim_lt(hi_x, lo_x);
    assign in_range = prim_ge(s_x, hi_x) & prim_lt(s_x, lo_p1);

    always_comb begin
        verdict = '0;
        unique case ({low_en, high_en})
            2'b10: begin
                verdict.low_side = prim_lt(s_x, lo_p1);
            end
            2'b01: begin
                verdict.high_side = prim_ge(s_x, hi_x);
            end
            2'b11: begin
                if (inverted) begin
                    verdict.low_side  = in_range;
                    verdict.high_side = in_range;
                end else begin
                    verdict.low_side  = prim_lt(s_x, lo_x);
                    verdict.high_side = prim_ge(s_x, hi_p1);
                end
            end
            default: begin
                verdict.low_side  = 1'b0;
                verdict.high_side = 1'b0;
            end
        endcase
        verdict.hit = verdict.low_side | verdict.high_side;
    end

endmodule

// File: rtl/adc_wm_fsm.sv
module adc_wm_fsm
    import adc_wm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      smp_valid,
    input  logic      hit,
    output wm_state_e state,
    output logic      conv_req,
    output logic      capture
);
    wm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)             state_d = ST_ARMED;
            ST_ARMED: if (smp_valid && hit)  state_d = ST_DONE;
            ST_DONE:  if (start)             state_d = ST_ARMED;
            default:                         state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        conv_req = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                conv_req = 1'b1;
                capture  = smp_valid & hit;
            end
            default: begin
                conv_req = 1'b0;
                capture  = 1'b0;
            end
        endcase
    end

    assign state = state_q;

    // R7: non-matching or absent results keep the request alive
    a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !(smp_valid && hit)) |=> conv_req);

    // R7: start is the only way into ARMED
    a_r7_arm_by_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARMED && !start) |=> !conv_req);

endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
    import adc_wm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              irq_clear,
    input  logic              low_en,
    input  logic              high_en,
    input  logic              wide_mode,
    input  logic [DATA_W-1:0] low_thr,
    input  logic [DATA_W-1:0] high_thr,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              conv_req,
    output logic              irq,
    output logic [DATA_W-1:0] result_data,
    output logic              result_low,
    output logic              result_high
);
    logic [DATA_W-1:0] lo_s, hi_s, smp_s;
    wm_verdict_t       verdict;
    wm_state_e         state;
    logic              capture;

    adc_wm_scale #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_scale (
        .wide_mode (wide_mode),
        .low_thr   (low_thr),
        .high_thr  (high_thr),
        .smp_data  (smp_data),
        .lo_s      (lo_s),
        .hi_s      (hi_s),
        .smp_s     (smp_s)
    );

    adc_wm_compare #(.W(DATA_W)) u_cmp (
        .low_en  (low_en),
        .high_en (high_en),
        .lo      (lo_s),
        .hi      (hi_s),
        .smp     (smp_s),
        .verdict (verdict)
    );

    adc_wm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .smp_valid (smp_valid),
        .hit       (verdict.hit),
        .state     (state),
        .conv_req  (conv_req),
        .capture   (capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq         <= 1'b0;
            result_data <= '0;
            result_low  <= 1'b0;
            result_high <= 1'b0;
        end else begin
            if (capture) begin
                result_data <= smp_s;
                result_low  <= verdict.low_side;
                result_high <= verdict.high_side;
            end
            if (capture)        irq <= 1'b1;   // set wins over clear
            else if (irq_clear) irq <= 1'b0;
        end
    end

    // R2: low-only, inclusive bound ends monitoring
    a_r2_low_only_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && smp_valid && low_en && !high_en && smp_s <= lo_s)
        |=> (irq && !conv_req && result_low));

    // R3: high-only, inclusive bound ends monitoring
    a_r3_high_only_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && smp_valid && high_en && !low_en && smp_s >= hi_s)
        |=> (irq && !conv_req && result_high));

    // R8: the captured value is the compared sample
    a_r8_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && capture) |=> (irq && result_data == $past(smp_s)));

    // R9: interrupt is sticky until cleared
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    // R11: results are frozen while not armed
    a_r11_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_req) |=> ($stable(result_data) && $stable(result_low) && $stable(result_high)));

    // R6: without any enable, monitoring never finishes
    a_r6_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !low_en && !high_en) |=> conv_req);

endmodule

// File: tb/adc_window_monitor_test.sv
module adc_window_monitor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        irq_clear = 1'b0;
    logic        low_en = 1'b0;
    logic        high_en = 1'b0;
    logic        wide_mode = 1'b1;
    logic [15:0] low_thr = '0;
    logic [15:0] high_thr = '0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        conv_req, irq, result_low, result_high;
    logic [15:0] result_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit m_armed = 0;
    bit prev_req = 0;
    logic [17:0] exp_q[$];   // {low, high, data}

    always #5 clk = ~clk;

    adc_window_monitor uut (
        .clk(clk), .rst_n(rst_n), .start(start), .irq_clear(irq_clear),
        .low_en(low_en), .high_en(high_en), .wide_mode(wide_mode),
        .low_thr(low_thr), .high_thr(high_thr),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .conv_req(conv_req), .irq(irq), .result_data(result_data),
        .result_low(result_low), .result_high(result_high)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference decision, written from the requirements
    function automatic logic [17:0] ref_eval(input int s_in);
        int s, lo, hi;
        bit l, h;
        s  = wide_mode ? s_in : (s_in & 'hFFF);
        lo = wide_mode ? int'(low_thr)  : int'(low_thr)  / 16;
        hi = wide_mode ? int'(high_thr) : int'(high_thr) / 16;
        l = 0; h = 0;
        if (low_en && !high_en) l = (s <= lo);
        else if (high_en && !low_en) h = (s >= hi);
        else if (low_en && high_en) begin
            if (lo > hi) begin l = (s >= hi && s <= lo); h = l; end
            else begin l = (s < lo); h = (s > hi); end
        end
        return {l, h, 16'(s)};
    endfunction

    task automatic arm();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        m_armed = 1;
        chk(conv_req === 1'b1, "R7 request after start", conv_req, 1);
    endtask

    task automatic send(input int s, input bit clr);
        logic [17:0] e;
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 16'(s); irq_clear = clr;
        e = ref_eval(s);
        if (m_armed && (e[17] || e[16])) begin
            exp_q.push_back(e);
            m_armed = 0;
        end
        @(negedge clk);
        smp_valid = 1'b0; irq_clear = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clear = 1'b1;
        @(negedge clk); irq_clear = 1'b0;
        chk(irq === 1'b0, "R9 clear drops irq", irq, 0);
    endtask

    // Scoreboard monitor: each fall of conv_req must match the next expected capture
    always @(negedge clk) begin
        if (rst_n && prev_req && !conv_req) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7/R8 unexpected stop", result_data, 0);
            end else begin
                logic [17:0] e;
                e = exp_q.pop_front();
                chk(result_data === e[15:0], "R8 result_data", result_data, e[15:0]);
                chk(result_low === e[17], "R4/R5 result_low", result_low, e[17]);
                chk(result_high === e[16], "R4/R5 result_high", result_high, e[16]);
                chk(irq === 1'b1, "R8 irq raised", irq, 1);
            end
        end
        prev_req <= conv_req;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(conv_req === 1'b0, "R1 conv_req", conv_req, 0);
        chk(irq === 1'b0, "R1 irq", irq, 0);
        chk(result_data === 16'h0, "R1 result_data", result_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 low-only, 16-bit
        low_en = 1; high_en = 0; low_thr = 16'h5000; high_thr = 16'h0;
        arm();
        send('h6000, 0); send('h5001, 0);
        chk(conv_req === 1'b1, "R7 holds through misses", conv_req, 1);
        send('h5000, 0);
        @(negedge clk);
        chk(conv_req === 1'b0, "R2 boundary stops request", conv_req, 0);

        // R11 ignored while done
        send('h1234, 0);
        chk(result_data === 16'h5000, "R11 result frozen", result_data, 16'h5000);
        chk(irq === 1'b1, "R11 irq unchanged", irq, 1);
        clear_irq();
        send('h0001, 0);
        chk(irq === 1'b0, "R11 no irq when idle", irq, 0);

        // R3 high-only
        low_en = 0; high_en = 1; high_thr = 16'hA000;
        arm();
        send('h9FFF, 0);
        start = 1'b0;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        chk(conv_req === 1'b1, "R7 start while armed", conv_req, 1);
        send('hA000, 0);
        @(negedge clk);
        chk(irq === 1'b1, "R9 sticky without clear", irq, 1);
        clear_irq();

        // R4 out of range, strict bounds
        low_en = 1; high_en = 1; low_thr = 16'h4000; high_thr = 16'hC000;
        arm();
        send('h4000, 0); send('hC000, 0); send('h8000, 0);
        chk(conv_req === 1'b1, "R4 bounds do not match", conv_req, 1);
        send('h3FFF, 0);
        arm();
        send('hC001, 0);

        // R5 in range, inclusive bounds
        low_thr = 16'hC000; high_thr = 16'h4000;
        arm();
        send('h3FFF, 0); send('hC001, 0);
        chk(conv_req === 1'b1, "R5 outside ignored", conv_req, 1);
        send('h4000, 0);
        arm();
        send('hC000, 0);

        // R6 no enable
        low_en = 0; high_en = 0;
        arm();
        send('h0000, 0); send('hFFFF, 0);
        @(negedge clk);
        chk(conv_req === 1'b1, "R6 never matches", conv_req, 1);
        low_en = 1; low_thr = 16'h0100;
        send('h0050, 0);

        // R10 12-bit scaling: 0x5000 -> 0x500
        wide_mode = 0; low_en = 1; high_en = 0; low_thr = 16'h5000;
        arm();
        send('hF501, 0);
        chk(conv_req === 1'b1, "R10 upper bits ignored", conv_req, 1);
        send('hF500, 0);
        @(negedge clk);
        chk(result_data === 16'h0500, "R10 scaled result", result_data, 16'h0500);
        wide_mode = 1;

        // R9 collision: clear and match on one edge, set wins
        chk(irq === 1'b1, "R9 irq pending", irq, 1);
        arm();
        send('h0000, 1);
        @(negedge clk);
        chk(irq === 1'b1, "R9 set beats clear", irq, 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all captures seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule